// File: doc/BRIEF.md
# Vector Sum Reduction Engine

The engine totals an integer stream of arbitrary length. Elements arrive in beats that are `LANES` elements wide, with a valid/ready handshake and a flag that marks the final beat. Each accepted beat is added lane by lane into a register vector of partial sums. This keeps one independent accumulator per lane and avoids a single serial accumulator that would limit throughput.

When the final beat has been accepted, the engine stops taking input and folds the partial vector. Each step adds the upper half of the still-active partials into the lower half and halves the active length. It repeats until one element remains. That element is presented on `sum_o` together with a one-cycle `sum_valid_o`. In the same cycle the partials return to zero, ready for the next job.

A beat can carry fewer than `LANES` useful elements. Its `in_count_i` field gives how many low lanes are used, and the other lanes count as zero.

Top module: `vec_sum_reduce`

## Requirements
- R1: After reset `in_ready_o` is 1 and `sum_valid_o` is 0.
- R2: The partial sums start from zero after reset and after every result, so each job's `sum_o` equals only the sum of the elements accepted in that job.
- R3: All additions wrap modulo 2^`DW` (32 bits by default) and never saturate.
- R4: On any accepted beat, lane i (element bits `[i*DW +: DW]` of `in_data_i`) contributes only when i < `in_count_i`. Lanes at or above the count contribute zero. A count of `LANES` or more uses every lane, and a count of 0 adds nothing.
- R5: `sum_valid_o` rises exactly log2(`LANES`) clock edges after the edge that accepts the beat with `in_last_i` = 1, and it stays high for exactly one cycle.
- R6: From the edge that accepts the last beat until the result edge, `in_ready_o` is 0. Input offered in that window is not consumed and has no effect on any result.
- R7: While `in_valid_i` is 0, the values on `in_data_i`, `in_count_i` and `in_last_i` have no effect.
- R8: A job can consist of a single beat that has `in_last_i` = 1.
- R9: `in_ready_o` is 1 in the cycle that `sum_valid_o` is high, so the first beat of the next job can be accepted there, back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Beat offered |
| in_ready_o | output | 1 | Engine accepts a beat this cycle |
| in_data_i | input | LANES*DW | Beat elements; lane i is bits [i*DW +: DW] |
| in_count_i | input | $clog2(LANES+1) | Number of low lanes that carry data |
| in_last_i | input | 1 | Beat closes the current job |
| sum_o | output | DW | Job total, valid when sum_valid_o is 1 |
| sum_valid_o | output | 1 | One-cycle result strobe |

## Verification
The bench runs jobs of several kinds:
- Jobs built from random full-range words check that every lane and every fold level is added. A missing or misrouted lane changes the total.
- Jobs made only of all-ones words separate modulo wrap from saturation.
- Small-valued jobs with short final counts, including 0 and counts above `LANES`, show whether padding masks exactly the lanes at or above the count.
- Jobs with idle gaps carrying junk data, and with junk offered during the fold, show whether the engine consumes only handshaken beats.
- A single-beat job placed directly after a result tests zero restart and back-to-back acceptance.

// File: rtl/vsr_pkg.sv
package vsr_pkg;
  typedef enum logic {
    ST_ACC = 1'b0,
    ST_RED = 1'b1
  } vsr_state_e;
endpackage

// File: rtl/vsr_lane_mask.sv
module vsr_lane_mask #(
  parameter int LANES = 8,
  parameter int DW    = 32,
  localparam int CW   = $clog2(LANES + 1)
) (
  input  logic [LANES*DW-1:0]       data_i,
  input  logic [CW-1:0]             cnt_i,
  output logic [LANES-1:0][DW-1:0]  lane_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [CW:0] IDX = (CW+1)'(i);
    assign lane_o[i] = (IDX < {1'b0, cnt_i}) ? data_i[i*DW +: DW] : '0;
  end
endmodule

// File: rtl/vsr_halve.sv
module vsr_halve #(
  parameter int LANES  = 8,
  parameter int DW     = 32,
  localparam int LEVELS = $clog2(LANES),
  localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic [LANES-1:0][DW-1:0] part_i,
  input  logic [LVL_W-1:0]         lvl_i,
  output logic [LANES-1:0][DW-1:0] part_o
);
  logic [LEVELS-1:0][LANES-1:0][DW-1:0] cand;

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
    localparam int HALF = LANES >> (lv + 1);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      if (i < HALF) begin : g_fold
        assign cand[lv][i] = part_i[i] + part_i[i+HALF];
      end else begin : g_zero
        assign cand[lv][i] = '0;
      end
    end
  end

  always_comb begin
    part_o = cand[0];
    for (int lv = 0; lv < LEVELS; lv++) begin
      if (lvl_i == LVL_W'(lv)) part_o = cand[lv];
    end
  end
endmodule

// File: rtl/vsr_ctrl.sv
module vsr_ctrl
  import vsr_pkg::*;
#(
  parameter int LANES  = 8,
  localparam int LEVELS = $clog2(LANES),
  localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic             last_i,
  output logic             ready_o,
  output logic             step_o,
  output logic             done_o,
  output logic [LVL_W-1:0] lvl_o
);
  vsr_state_e state_q;
  logic [LVL_W-1:0] lvl_q;

  assign ready_o = (state_q == ST_ACC);
  assign step_o  = (state_q == ST_RED);
  assign done_o  = step_o && (lvl_q == LVL_W'(LEVELS - 1));
  assign lvl_o   = lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ACC;
      lvl_q   <= '0;
    end else begin
      unique case (state_q)
        ST_ACC: if (fire_i && last_i) begin
          state_q <= ST_RED;
          lvl_q   <= '0;
        end
        ST_RED: begin
          lvl_q <= lvl_q + 1'b1;
          if (done_o) state_q <= ST_ACC;
        end
        default: state_q <= ST_ACC;
      endcase
    end
  end
endmodule

// File: rtl/vec_sum_reduce.sv
module vec_sum_reduce #(
  parameter int LANES  = 8,
  parameter int DW     = 32,
  localparam int CW    = $clog2(LANES + 1),
  localparam int LEVELS = $clog2(LANES),
  localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [LANES*DW-1:0] in_data_i,
  input  logic [CW-1:0]       in_count_i,
  input  logic                in_last_i,
  output logic [DW-1:0]       sum_o,
  output logic                sum_valid_o
);
  logic fire, step, done;
  logic [LVL_W-1:0] lvl;
  logic [LANES-1:0][DW-1:0] beat, part_q, folded;

  assign fire = in_valid_i && in_ready_o;

  vsr_ctrl #(.LANES(LANES)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .last_i  (in_last_i),
    .ready_o (in_ready_o),
    .step_o  (step),
    .done_o  (done),
    .lvl_o   (lvl)
  );

  vsr_lane_mask #(.LANES(LANES), .DW(DW)) u_mask (
    .data_i (in_data_i),
    .cnt_i  (in_count_i),
    .lane_o (beat)
  );

  vsr_halve #(.LANES(LANES), .DW(DW)) u_halve (
    .part_i (part_q),
    .lvl_i  (lvl),
    .part_o (folded)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_part
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   part_q[i] <= '0;
      else if (done) part_q[i] <= '0;            // restart next job from zero
      else if (step) part_q[i] <= folded[i];
      else if (fire) part_q[i] <= part_q[i] + beat[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o       <= '0;
      sum_valid_o <= 1'b0;
    end else begin
      sum_valid_o <= done;
      if (done) sum_o <= folded[0];
    end
  end
endmodule

// File: rtl/vsr_checker.sv
module vsr_checker #(
  parameter int LANES = 8,
  localparam int LEVELS = $clog2(LANES)
) (
  input logic clk_i,
  input logic rst_ni,
  input logic in_valid_i,
  input logic in_ready_o,
  input logic in_last_i,
  input logic sum_valid_o
);
  // cycles since the last beat was taken; result expected at LEVELS+1
  logic [7:0] since_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_q <= '0;
    else if (in_valid_i && in_ready_o && in_last_i) since_q <= 8'd1;
    else if (since_q == 8'(LEVELS + 1)) since_q <= '0;
    else if (since_q != '0) since_q <= since_q + 8'd1;
  end

  p_result_timing_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_valid_o |-> (since_q == 8'(LEVELS + 1)));
  p_result_due_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q == 8'(LEVELS + 1)) |-> sum_valid_o);
  p_one_cycle_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_valid_o |=> !sum_valid_o);
  p_stall_in_fold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q != '0 && since_q <= 8'(LEVELS)) |-> !in_ready_o);
  p_ready_with_result_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_valid_o |-> in_ready_o);
  p_idle_ready_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q == '0) |-> in_ready_o);
endmodule

bind vec_sum_reduce vsr_checker #(.LANES(LANES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_last_i   (in_last_i),
  .sum_valid_o (sum_valid_o)
);

// File: tb/vec_sum_reduce_test.sv
module vec_sum_reduce_test;
  localparam int LANES = 8;
  localparam int DW    = 32;
  localparam int CW    = $clog2(LANES + 1);
  localparam int LEVELS = $clog2(LANES);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, in_ready, sum_valid;
  logic [LANES*DW-1:0] in_data = '0;
  logic [CW-1:0] in_count = '0;
  logic [DW-1:0] sum;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  vec_sum_reduce #(.LANES(LANES), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_data_i(in_data), .in_count_i(in_count), .in_last_i(in_last),
    .sum_o(sum), .sum_valid_o(sum_valid)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] gen(input int mode);
    case (mode)
      1:       return '1;
      2:       return DW'($urandom_range(0, 255));
      default: return DW'($urandom);
    endcase
  endfunction

  function automatic logic [LANES*DW-1:0] junk();
    logic [LANES*DW-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*DW +: DW] = DW'($urandom);
    return v;
  endfunction

  // checks the fold window after the last beat's accept edge; caller is just past that edge
  task automatic watch_result(input logic [DW-1:0] exp, input bit poke, input string tag);
    for (int k = 0; k < LEVELS; k++) begin
      @(negedge clk);
      if (poke) begin
        in_valid = 1'b1; in_data = junk(); in_count = CW'(LANES); in_last = 1'b1;
      end else begin
        in_valid = 1'b0; in_data = junk(); in_count = CW'($urandom); in_last = 1'b1;
      end
      chk(!in_ready, {"R6 ready low in fold ", tag}, DW'(in_ready), '0);
      chk(!sum_valid, {"R5 no early result ", tag}, DW'(sum_valid), '0);
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(sum_valid, {"R5 result strobe ", tag}, DW'(sum_valid), 1);
    chk(sum == exp, {"R2 R3 sum value ", tag}, sum, exp);
    chk(in_ready, {"R9 ready with result ", tag}, DW'(in_ready), 1);
    @(negedge clk);
    chk(!sum_valid, {"R5 single cycle ", tag}, DW'(sum_valid), '0);
  endtask

  task automatic do_job(input int nb, input int mode, input int last_cnt,
                        input bit gaps, input bit poke, input string tag);
    logic [DW-1:0] exp = '0;
    for (int b = 0; b < nb; b++) begin
      int cnt = (b == nb - 1) ? last_cnt : LANES;
      @(negedge clk);
      if (gaps) begin  // R7: junk with valid low
        in_valid = 1'b0; in_data = junk(); in_last = 1'b1; in_count = CW'(LANES);
        @(negedge clk);
      end
      while (!in_ready) @(negedge clk);
      for (int i = 0; i < LANES; i++) begin
        logic [DW-1:0] v = gen(mode);
        in_data[i*DW +: DW] = v;
        if (i < cnt) exp += v;  // R4 padding
      end
      in_count = CW'(cnt);
      in_last  = (b == nb - 1);
      in_valid = 1'b1;
      @(posedge clk);
    end
    watch_result(exp, poke, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    #1;
    chk(in_ready, "R1 ready in reset", DW'(in_ready), 1);
    chk(!sum_valid, "R1 no result in reset", DW'(sum_valid), '0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready, "R1 ready after reset", DW'(in_ready), 1);
    chk(!sum_valid, "R1 idle after reset", DW'(sum_valid), '0);

    do_job(4, 0, LANES, 0, 0, "R2 random full");
    do_job(2, 1, LANES, 0, 0, "R3 all ones wrap");
    do_job(3, 2, 3, 0, 0, "R4 count 3");
    do_job(2, 2, 0, 0, 0, "R4 count 0");
    do_job(2, 2, 13, 0, 0, "R4 count over");
    do_job(1, 0, 1, 0, 0, "R8 single beat lane0");
    do_job(3, 0, LANES, 1, 0, "R7 gaps");
    do_job(2, 0, LANES, 0, 1, "R6 poke in fold");

    // R9 back to back: first beat of next job taken while result is shown
    begin
      logic [DW-1:0] e1 = '0, e2 = '0;
      @(negedge clk);
      for (int i = 0; i < LANES; i++) begin
        in_data[i*DW +: DW] = gen(0); e1 += in_data[i*DW +: DW];
      end
      in_count = CW'(LANES); in_last = 1'b1; in_valid = 1'b1;
      @(posedge clk);
      for (int k = 0; k < LEVELS; k++) begin
        @(negedge clk); in_valid = 1'b0;
      end
      @(negedge clk);
      chk(sum_valid && sum == e1, "R9 first result", sum, e1);
      for (int i = 0; i < LANES; i++) begin
        in_data[i*DW +: DW] = gen(2); e2 += in_data[i*DW +: DW];
      end
      in_count = CW'(LANES); in_last = 1'b1; in_valid = 1'b1;
      chk(in_ready, "R9 accept with result", DW'(in_ready), 1);
      @(posedge clk);
      watch_result(e2, 0, "R9 second job");
    end

    for (int j = 0; j < 12; j++)
      do_job($urandom_range(1, 6), $urandom_range(0, 2), $urandom_range(0, LANES),
             $urandom_range(0, 1), $urandom_range(0, 1), "R2 random job");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule